// File: doc/BRIEF.md
# External Half-Word Memory Bus Controller

This block is a slave on a 32-bit processor bus that serves reads and writes to up to four external asynchronous memory banks, such as NOR flash or static RAM. All banks share one 16-bit data bus and one half-word address bus. Each bank has its own active-low chip enable. Every 32-bit bus word is carried as two ordered half-word accesses. A request asks for either one word or a line of four consecutive words.

Four configuration registers are written through a small register port, one per bank. Each register gives its bank an enable, an address window and three timing counts. A request is decoded once, when it is accepted. The controller then acknowledges the address and runs the half-word accesses. Each access has its own setup, strobe and hold phases, followed by an idle cycle. After the last word the controller raises a completion pulse of the matching direction. Any command sequencing that flash parts need is left to software.

Top module: `ext_mem_ctrl`

## Requirements
- R1: A word write of byte address A stores `wdata[31:16]` at half-word address `A[23:1]` and then `wdata[15:0]` at `A[23:1]+1`.
- R2: A word read returns `{half(A[23:1]), half(A[23:1]+1)}` on `rdata_o` while `rd_beat_o` is high.
- R3: With `req_line_i` set, four words are moved at eight consecutive half-word addresses, with four `wr_beat_o` or `rd_beat_o` pulses. In a line write, `wdata_i` must hold the next word once the previous `wr_beat_o` has been seen.
- R4: `addr_ack_o` is high for exactly the one cycle after the request cycle. After the last beat, `wr_done_o` pulses for a write and `rd_done_o` pulses for a read. The two never pulse together.
- R5: Each configuration register is laid out as follows. Bit 31 is the bank enable. Bits 30:23 are the base, compared with request address bits 31:24. Bits 20, 21 and 22 form the size code, with bit 20 as the MSB. Bits 11:8 are the setup count, bits 7:4 the strobe count and bits 3:0 the hold count. The register is written when `cfg_we_i` is high and selected by `cfg_sel_i`.
- R6: Size codes 0 to 5 give a window of 512 KiB shifted left by the code (4 to 128 Mbit). Within one access, chip enable is low for setup+1 cycles before the strobe. The strobe (`mem_oe_no` for reads, `mem_we_no` for writes) is low for strobe+1 cycles. Chip enable then stays low for hold cycles.
- R7: Between any two half-word accesses, all chip enables and `mem_we_no` are high for at least one cycle. A word therefore produces two separate chip-enable pulses.
- R8: A request that hits no enabled bank, falls outside the bank window, or selects a bank with size code 6 or 7 is still address-acknowledged. It then completes with `err_o` high alongside the done pulse and drives no chip enable or strobe.
- R9: The controller drives `mem_dq_io` only during a write, while `mem_we_no` is low and for the hold cycles after it. At all other times the pin is high impedance.
- R10: When several enabled, valid banks match an address, the lowest-numbered bank is used.
- R11: At most one chip enable is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_sel_i | input | 2 | Bank register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_i | input | 1 | Request qualifier, one cycle, accepted while idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_line_i | input | 1 | 1 = four-word line, 0 = single word |
| req_addr_i | input | 32 | Byte address of first word |
| wdata_i | input | 32 | Write data of current word |
| addr_ack_o | output | 1 | Address acknowledge pulse |
| wr_beat_o | output | 1 | A write word has been taken |
| rd_beat_o | output | 1 | `rdata_o` holds a read word |
| rdata_o | output | 32 | Assembled read word |
| rd_done_o | output | 1 | Read complete pulse |
| wr_done_o | output | 1 | Write complete pulse |
| err_o | output | 1 | Error flag, valid with a done pulse |
| mem_ce_no | output | 4 | Per-bank chip enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_addr_o | output | 23 | Half-word address |
| mem_dq_io | inout | 16 | Shared data bus |

## Verification
The assertions assume the following about the inputs. A request is a one-cycle pulse issued only while the controller is idle. The configuration of a bank is not rewritten while that bank is being accessed. The external memory drives the data bus only while output enable and a chip enable are both low. The stimulus issues each request with a task that waits for the done pulse before it returns. It writes configuration only between transfers. Its memory model drives the bus under exactly the enable condition above, so the drive checks and gap checks see only legal traffic.

// File: rtl/emc_pkg.sv
package emc_pkg;

  typedef struct packed {
    logic       en;
    logic [7:0] base;
    logic [2:0] size;
    logic [3:0] setup;
    logic [3:0] strobe;
    logic [3:0] hold;
  } bank_cfg_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ACK, S_SETUP, S_STROBE, S_HOLD, S_GAP, S_DONE
  } seq_st_t;

  localparam logic [2:0] SIZE_CODE_MAX = 3'd5;
  localparam int         WIN_SHIFT_MIN = 19;  // 4 Mbit window = 2^19 bytes

  // size code: bit 20 is the MSB of the field
  function automatic bank_cfg_t cfg_from_word(logic [31:0] w);
    bank_cfg_t c;
    c.en     = w[31];
    c.base   = w[30:23];
    c.size   = {w[20], w[21], w[22]};
    c.setup  = w[11:8];
    c.strobe = w[7:4];
    c.hold   = w[3:0];
    return c;
  endfunction

endpackage

// File: rtl/emc_cfg_regs.sv
module emc_cfg_regs
  import emc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BW = $clog2(NUM_BANKS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cfg_we_i,
  input  logic [BW-1:0]                   cfg_sel_i,
  input  logic [31:0]                     cfg_wdata_i,
  output bank_cfg_t [NUM_BANKS-1:0]       cfg_o
);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_wdata_i[19:12];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                cfg_o[b] <= '0;
      else if (cfg_we_i && cfg_sel_i == BW'(b))   cfg_o[b] <= cfg_from_word(cfg_wdata_i);
    end
  end

endmodule

// File: rtl/emc_bank_decode.sv
module emc_bank_decode
  import emc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int MEM_AW    = 23,
  localparam int BW    = $clog2(NUM_BANKS),
  localparam int WIN_W = MEM_AW + 1
) (
  input  bank_cfg_t [NUM_BANKS-1:0] cfg_i,
  input  logic [31:0]               addr_i,
  output logic                      hit_o,
  output logic [BW-1:0]             idx_o,
  output logic [MEM_AW-1:0]         hw_addr_o
);

  logic [NUM_BANKS-1:0] ok;
  logic unused_lsb;
  assign unused_lsb = addr_i[0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    logic [WIN_W:0] lim;
    assign lim   = (WIN_W+1)'(1) << (5'(WIN_SHIFT_MIN) + 5'(cfg_i[b].size));
    assign ok[b] = cfg_i[b].en && (cfg_i[b].size <= SIZE_CODE_MAX)
                && (addr_i[31:WIN_W] == cfg_i[b].base)
                && ({1'b0, addr_i[WIN_W-1:0]} < lim);
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (ok[b]) begin
        hit_o = 1'b1;
        idx_o = BW'(b);
      end
    end
  end

  assign hw_addr_o = addr_i[MEM_AW:1];

endmodule

// File: rtl/emc_seq.sv
module emc_seq
  import emc_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int MEM_AW     = 23,
  parameter int LINE_WORDS = 4,
  localparam int BW = $clog2(NUM_BANKS),
  localparam int LW = $clog2(LINE_WORDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 req_we_i,
  input  logic                 req_line_i,
  input  logic [31:0]          wdata_i,
  input  logic                 hit_i,
  input  logic [BW-1:0]        bank_i,
  input  logic [MEM_AW-1:0]    hw_addr_i,
  input  logic [3:0]           setup_i,
  input  logic [3:0]           strobe_i,
  input  logic [3:0]           hold_i,
  input  logic [15:0]          dq_i,
  output logic [BW-1:0]        bank_o,
  output logic                 addr_ack_o,
  output logic                 wr_beat_o,
  output logic                 rd_beat_o,
  output logic [31:0]          rdata_o,
  output logic                 rd_done_o,
  output logic                 wr_done_o,
  output logic                 err_o,
  output logic [NUM_BANKS-1:0] ce_no,
  output logic                 oe_no,
  output logic                 we_no,
  output logic [MEM_AW-1:0]    addr_o,
  output logic [15:0]          dq_o,
  output logic                 dq_oe_o
);

  seq_st_t           st_q;
  logic              err_q, we_q, line_q, half_q;
  logic [LW-1:0]     beat_q;
  logic [3:0]        cnt_q;
  logic [MEM_AW-1:0] addr_q;
  logic [31:0]       wd_q, rd_q;
  logic              wr_beat_q, rd_beat_q;
  logic              last_beat;

  assign last_beat = !line_q || (beat_q == LW'(LINE_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; err_q <= 1'b0; we_q <= 1'b0; line_q <= 1'b0;
      half_q <= 1'b0; beat_q <= '0; cnt_q <= '0; addr_q <= '0;
      wd_q <= '0; rd_q <= '0; wr_beat_q <= 1'b0; rd_beat_q <= 1'b0;
      bank_o <= '0;
    end else begin
      wr_beat_q <= 1'b0;
      rd_beat_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_i) begin
          we_q      <= req_we_i;
          line_q    <= req_line_i;
          bank_o    <= bank_i;
          err_q     <= !hit_i;
          addr_q    <= hw_addr_i;
          wd_q      <= wdata_i;
          half_q    <= 1'b0;
          beat_q    <= '0;
          cnt_q     <= '0;
          wr_beat_q <= req_we_i && hit_i;
          st_q      <= S_ACK;
        end
        S_ACK: st_q <= err_q ? S_DONE : S_SETUP;
        S_SETUP: begin
          if (cnt_q == setup_i) begin cnt_q <= '0; st_q <= S_STROBE; end
          else cnt_q <= cnt_q + 4'd1;
        end
        S_STROBE: begin
          if (cnt_q == strobe_i) begin
            cnt_q <= '0;
            st_q  <= (hold_i == 4'd0) ? S_GAP : S_HOLD;
            if (!we_q) begin
              if (half_q) begin rd_q[15:0] <= dq_i; rd_beat_q <= 1'b1; end
              else rd_q[31:16] <= dq_i;
            end
          end else cnt_q <= cnt_q + 4'd1;
        end
        S_HOLD: begin
          if (cnt_q == hold_i - 4'd1) begin cnt_q <= '0; st_q <= S_GAP; end
          else cnt_q <= cnt_q + 4'd1;
        end
        S_GAP: begin
          addr_q <= addr_q + MEM_AW'(1);
          if (!half_q) begin
            half_q <= 1'b1;
            st_q   <= S_SETUP;
          end else if (last_beat) begin
            st_q <= S_DONE;
          end else begin
            half_q    <= 1'b0;
            beat_q    <= beat_q + LW'(1);
            wd_q      <= wdata_i;
            wr_beat_q <= we_q;
            st_q      <= S_SETUP;
          end
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  logic active;
  assign active     = (st_q == S_SETUP) || (st_q == S_STROBE) || (st_q == S_HOLD);
  assign ce_no      = active ? ~(NUM_BANKS'(1) << bank_o) : '1;
  assign oe_no      = !(st_q == S_STROBE && !we_q);
  assign we_no      = !(st_q == S_STROBE && we_q);
  assign dq_oe_o    = we_q && ((st_q == S_STROBE) || (st_q == S_HOLD));
  assign dq_o       = half_q ? wd_q[15:0] : wd_q[31:16];
  assign addr_o     = addr_q;
  assign addr_ack_o = (st_q == S_ACK);
  assign rd_done_o  = (st_q == S_DONE) && !we_q;
  assign wr_done_o  = (st_q == S_DONE) && we_q;
  assign err_o      = (st_q == S_DONE) && err_q;
  assign wr_beat_o  = wr_beat_q;
  assign rd_beat_o  = rd_beat_q;
  assign rdata_o    = rd_q;

  // R4: address acknowledge is a single-cycle pulse
  a_r4_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ack_o |=> !addr_ack_o);
  // R4: completion never coincides with the address acknowledge
  a_r4_done_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done_o || wr_done_o) |-> (!addr_ack_o && !(rd_done_o && wr_done_o)));
  // R6: a strobe starts only with chip enable already low on the same bank
  a_r6_setup_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_no && we_no) |-> (!(&$past(ce_no)) && $stable(ce_no)));

endmodule

// File: rtl/ext_mem_ctrl.sv
module ext_mem_ctrl
  import emc_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int MEM_AW     = 23,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [$clog2(NUM_BANKS)-1:0] cfg_sel_i,
  input  logic [31:0]                  cfg_wdata_i,
  input  logic                         req_i,
  input  logic                         req_we_i,
  input  logic                         req_line_i,
  input  logic [31:0]                  req_addr_i,
  input  logic [31:0]                  wdata_i,
  output logic                         addr_ack_o,
  output logic                         wr_beat_o,
  output logic                         rd_beat_o,
  output logic [31:0]                  rdata_o,
  output logic                         rd_done_o,
  output logic                         wr_done_o,
  output logic                         err_o,
  output logic [NUM_BANKS-1:0]         mem_ce_no,
  output logic                         mem_oe_no,
  output logic                         mem_we_no,
  output logic [MEM_AW-1:0]            mem_addr_o,
  inout  wire  [15:0]                  mem_dq_io
);

  localparam int BW = $clog2(NUM_BANKS);

  bank_cfg_t [NUM_BANKS-1:0] cfg;
  logic                      hit;
  logic [BW-1:0]             hit_idx, bank;
  logic [MEM_AW-1:0]         hw_addr;
  logic [15:0]               dq_out;
  logic                      dq_oe;

  emc_cfg_regs #(.NUM_BANKS(NUM_BANKS)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i, .cfg_o(cfg)
  );

  emc_bank_decode #(.NUM_BANKS(NUM_BANKS), .MEM_AW(MEM_AW)) u_dec (
    .cfg_i(cfg), .addr_i(req_addr_i), .hit_o(hit), .idx_o(hit_idx), .hw_addr_o(hw_addr)
  );

  emc_seq #(.NUM_BANKS(NUM_BANKS), .MEM_AW(MEM_AW), .LINE_WORDS(LINE_WORDS)) u_seq (
    .clk_i, .rst_ni, .req_i, .req_we_i, .req_line_i, .wdata_i,
    .hit_i(hit), .bank_i(hit_idx), .hw_addr_i(hw_addr),
    .setup_i(cfg[bank].setup), .strobe_i(cfg[bank].strobe), .hold_i(cfg[bank].hold),
    .dq_i(mem_dq_io), .bank_o(bank),
    .addr_ack_o, .wr_beat_o, .rd_beat_o, .rdata_o, .rd_done_o, .wr_done_o, .err_o,
    .ce_no(mem_ce_no), .oe_no(mem_oe_no), .we_no(mem_we_no), .addr_o(mem_addr_o),
    .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  assign mem_dq_io = dq_oe ? dq_out : 'z;

  // R11: never more than one bank selected
  a_r11_one_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_ce_no));
  // R7: chip enable cannot move between banks without an idle cycle
  a_r7_ce_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&mem_ce_no) && !(&$past(mem_ce_no))) |-> $stable(mem_ce_no));
  // R7: write enable low on two cycles means the same address
  a_r7_we_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && !$past(mem_we_no)) |-> $stable(mem_addr_o));
  // R8: an error completion was preceded by no memory activity
  a_r8_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (&mem_ce_no && &$past(mem_ce_no) && mem_oe_no && mem_we_no));
  // R9: bus driven only under a selected bank with output enable off
  a_r9_dq_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe |-> (mem_oe_no && !(&mem_ce_no)));

endmodule

// File: tb/ext_mem_ctrl_test.sv
`timescale 1ns/1ps
module ext_mem_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req = 1'b0, req_we = 1'b0, req_line = 1'b0;
  logic [31:0] req_addr = '0, wdata = '0;
  logic        addr_ack, wr_beat, rd_beat, rd_done, wr_done, err;
  logic [31:0] rdata;
  logic [3:0]  ce_n;
  logic        oe_n, we_n;
  logic [22:0] maddr;
  wire  [15:0] mem_dq;

  always #10 clk = ~clk;  // 50 MHz

  ext_mem_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .req_i(req), .req_we_i(req_we), .req_line_i(req_line),
    .req_addr_i(req_addr), .wdata_i(wdata), .addr_ack_o(addr_ack), .wr_beat_o(wr_beat),
    .rd_beat_o(rd_beat), .rdata_o(rdata), .rd_done_o(rd_done), .wr_done_o(wr_done),
    .err_o(err), .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_addr_o(maddr), .mem_dq_io(mem_dq)
  );

  // ---------------- memory model ----------------
  logic [15:0] mem [4][256];

  function automatic int bank_of(logic [3:0] c);
    for (int b = 0; b < 4; b++) if (!c[b]) return b;
    return 0;
  endfunction

  function automatic logic [15:0] pat(int b, int i);
    return 16'hA000 | 16'(b << 8) | 16'(i & 8'hFF);
  endfunction

  logic mdl_drv;
  assign mdl_drv = !oe_n && !(&ce_n);
  assign mem_dq  = mdl_drv ? mem[bank_of(ce_n)][maddr[7:0]] : 16'hzzzz;

  always @(negedge clk) if (!we_n && !(&ce_n)) mem[bank_of(ce_n)][maddr[7:0]] = mem_dq;

  // ---------------- bus monitor ----------------
  int n_cmp = 0, n_bad = 0;
  int viol = 0, runs = 0;
  int setup_r, strobe_r, hold_r, last_setup, last_strobe, last_hold;
  logic seen, prev_ce_low = 1'b0, prev_we_low = 1'b0;
  logic [3:0]  prev_ce = 4'hF;
  logic [22:0] prev_addr = '0;

  always @(negedge clk) if (rst_n) begin
    logic ce_low, str;
    ce_low = !(&ce_n);
    str    = !oe_n || !we_n;
    if (ce_low && prev_ce_low && ce_n != prev_ce) viol++;
    if (!we_n && prev_we_low && maddr != prev_addr) viol++;
    if (!ce_low && mem_dq !== 16'hzzzz) viol++;
    if (ce_low) begin
      if (!prev_ce_low) begin runs++; setup_r = 0; strobe_r = 0; hold_r = 0; seen = 1'b0; end
      if (str) begin strobe_r++; seen = 1'b1; end
      else if (!seen) begin setup_r++; if (mem_dq !== 16'hzzzz) viol++; end
      else hold_r++;
    end else if (prev_ce_low) begin
      last_setup = setup_r; last_strobe = strobe_r; last_hold = hold_r;
    end
    prev_ce_low = ce_low; prev_we_low = !we_n; prev_ce = ce_n; prev_addr = maddr;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(bit en, logic [7:0] base, logic [2:0] sz,
                                         logic [3:0] s, logic [3:0] t, logic [3:0] h);
    logic [31:0] w = '0;
    w[31] = en; w[30:23] = base;
    w[20] = sz[2]; w[21] = sz[1]; w[22] = sz[0];
    w[11:8] = s; w[7:4] = t; w[3:0] = h;
    return w;
  endfunction

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  logic [31:0] wd [4];
  logic [31:0] rd [4];
  logic        x_err;
  int          x_wb, x_rb;

  task automatic xfer(input bit we, input bit line, input logic [31:0] a);
    bit done = 0, ack_ok, type_ok = 0;
    x_wb = 0; x_rb = 0; x_err = 1'b0;
    @(negedge clk);
    req = 1'b1; req_we = we; req_line = line; req_addr = a; wdata = wd[0];
    @(negedge clk);
    req = 1'b0;
    ack_ok = addr_ack;
    chk(ack_ok, "R4 addr_ack one cycle after request", 32'(addr_ack), 32'd1);
    for (int t = 0; t < 3000 && !done; t++) begin
      if (wr_beat) begin x_wb++; if (x_wb < 4) wdata = wd[x_wb]; end
      if (rd_beat) begin if (x_rb < 4) rd[x_rb] = rdata; x_rb++; end
      if (rd_done || wr_done) begin
        done = 1; x_err = err;
        type_ok = we ? (wr_done && !rd_done) : (rd_done && !wr_done);
      end
      if (!done) @(negedge clk);
    end
    chk(done && type_ok, "R4 done pulse of matching direction", {rd_done, wr_done}, we ? 32'd1 : 32'd2);
  endtask

  // vector table: {is_write, byte address, data}
  localparam logic [64:0] VEC [6] = '{
    {1'b1, 32'h0000_0010, 32'h1234_ABCD},
    {1'b1, 32'h0100_0100, 32'hCAFE_0001},
    {1'b0, 32'h0000_0010, 32'h1234_ABCD},
    {1'b0, 32'h0100_0100, 32'hCAFE_0001},
    {1'b1, 32'h0100_0104, 32'h5A5A_0F0F},
    {1'b0, 32'h0100_0104, 32'h5A5A_0F0F}
  };

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- sequence ----------------
  initial begin
    int r0;
    for (int b = 0; b < 4; b++) for (int i = 0; i < 256; i++) mem[b][i] = pat(b, i);
    for (int i = 0; i < 4; i++) wd[i] = '0;
    repeat (3) @(negedge clk);
    // reset state
    chk(ce_n == 4'hF && oe_n && we_n, "R11 reset strobes idle", {ce_n, oe_n, we_n}, 32'h3F);
    chk(!addr_ack && !rd_done && !wr_done && !err, "R4 reset handshake idle",
        {addr_ack, rd_done, wr_done, err}, 32'd0);
    chk(mem_dq === 16'hzzzz, "R9 reset bus released", 32'(mem_dq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // no bank configured: error
    r0 = runs;
    xfer(1'b0, 1'b0, 32'h0000_0010);
    chk(x_err && runs == r0, "R8 unconfigured bank errors quietly", runs - r0, 32'd0);

    cfg_wr(2'd0, mk_cfg(1, 8'h00, 3'd0, 4'd2, 4'd3, 4'd1));
    cfg_wr(2'd1, mk_cfg(1, 8'h01, 3'd5, 4'd0, 4'd0, 4'd0));
    cfg_wr(2'd2, mk_cfg(1, 8'h02, 3'd7, 4'd0, 4'd0, 4'd0));

    // table walk
    foreach (VEC[k]) begin
      wd[0] = VEC[k][31:0];
      r0 = runs;
      xfer(VEC[k][64], 1'b0, VEC[k][63:32]);
      chk(!x_err, "R5 mapped access no error", 32'(x_err), 32'd0);
      chk(runs - r0 == 2, "R7 two chip-enable pulses per word", runs - r0, 32'd2);
      if (VEC[k][64]) chk(x_wb == 1, "R1 one write beat", x_wb, 32'd1);
      else chk(x_rb == 1 && rd[0] == VEC[k][31:0], "R2 read word assembled", rd[0], VEC[k][31:0]);
      if (VEC[k][63:32] == 32'h0000_0010 && VEC[k][64]) begin
        chk(mem[0][8] == 16'h1234 && mem[0][9] == 16'hABCD, "R1 upper half first address",
            {mem[0][8], mem[0][9]}, 32'h1234_ABCD);
        chk(last_setup == 3 && last_strobe == 4 && last_hold == 1, "R6 timing 2/3/1",
            {8'(last_setup), 8'(last_strobe), 8'(last_hold)}, 32'h030401);
      end
      if (VEC[k][63:32] == 32'h0100_0100 && VEC[k][64]) begin
        chk(mem[1][8'h80] == 16'hCAFE && mem[1][8'h81] == 16'h0001, "R1 bank1 halves",
            {mem[1][8'h80], mem[1][8'h81]}, 32'hCAFE_0001);
        chk(last_setup == 1 && last_strobe == 1 && last_hold == 0, "R6 timing 0/0/0",
            {8'(last_setup), 8'(last_strobe), 8'(last_hold)}, 32'h010100);
      end
    end

    // line read of preset pattern in bank 0 at 0x40 (half-words 0x20..0x27)
    r0 = runs;
    xfer(1'b0, 1'b1, 32'h0000_0040);
    chk(x_rb == 4 && runs - r0 == 8, "R3 line read beats and pulses", {16'(x_rb), 16'(runs - r0)}, 32'h0004_0008);
    for (int k = 0; k < 4; k++)
      chk(rd[k] == {pat(0, 32 + 2*k), pat(0, 33 + 2*k)}, "R3 line read word order",
          rd[k], {pat(0, 32 + 2*k), pat(0, 33 + 2*k)});

    // line write to bank 1 then read back
    wd[0] = 32'h0101_0202; wd[1] = 32'h0303_0404; wd[2] = 32'h0505_0606; wd[3] = 32'h0707_0808;
    xfer(1'b1, 1'b1, 32'h0100_0200);
    chk(x_wb == 4 && !x_err, "R3 line write takes four words", x_wb, 32'd4);
    chk(mem[1][0] == 16'h0101 && mem[1][1] == 16'h0202 && mem[1][6] == 16'h0707 && mem[1][7] == 16'h0808,
        "R3 line write placement", {mem[1][6], mem[1][7]}, 32'h0707_0808);
    xfer(1'b0, 1'b1, 32'h0100_0200);
    chk(rd[0] == 32'h0101_0202 && rd[1] == 32'h0303_0404 && rd[2] == 32'h0505_0606 && rd[3] == 32'h0707_0808,
        "R3 line read back", rd[3], 32'h0707_0808);

    // error cases
    r0 = runs;
    xfer(1'b0, 1'b0, 32'h0008_0000);
    chk(x_err, "R8 beyond 4 Mbit window", 32'(x_err), 32'd1);
    wd[0] = 32'hFFFF_FFFF;
    xfer(1'b1, 1'b0, 32'h0200_0000);
    chk(x_err && x_wb == 0, "R8 invalid size code", 32'(x_err), 32'd1);
    xfer(1'b0, 1'b0, 32'h0500_0000);
    chk(x_err, "R8 no matching bank", 32'(x_err), 32'd1);
    chk(runs == r0, "R8 no chip enable on errors", runs - r0, 32'd0);

    // overlap priority
    cfg_wr(2'd3, mk_cfg(1, 8'h00, 3'd0, 4'd0, 4'd0, 4'd0));
    wd[0] = 32'h1111_2222;
    xfer(1'b1, 1'b0, 32'h0000_0020);
    chk(mem[0][16] == 16'h1111 && mem[3][16] == pat(3, 16), "R10 lowest bank wins",
        {mem[0][16], mem[3][16]}, {16'h1111, pat(3, 16)});
    cfg_wr(2'd0, mk_cfg(0, 8'h00, 3'd0, 4'd2, 4'd3, 4'd1));
    wd[0] = 32'h3333_4444;
    xfer(1'b1, 1'b0, 32'h0000_0020);
    chk(mem[3][16] == 16'h3333 && mem[3][17] == 16'h4444 && mem[0][16] == 16'h1111,
        "R5 disabled bank falls through to next", {mem[3][16], mem[3][17]}, 32'h3333_4444);

    repeat (4) @(negedge clk);
    chk(viol == 0, "R7 R9 R11 bus monitor violations", viol, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule